// File: doc/BRIEF.md
# Multi-PHY Receive Cell-Available Responder

This block is the PHY-side answer logic for a shared receive bus of the UTOPIA Level 2 kind. One ATM-layer master and several PHY ports share one 5-bit address bus, one active-low enable and one cell-available wire. Each PHY holds a port address that software writes. On every rising edge of the receive clock the block samples the address bus and compares the sample with that port address. After a match it drives the shared cell-available wire for exactly one clock period, so the master can sample it one period after presenting the address. The driven level is high when the port's receive FIFO holds at least one whole cell. In every other cycle the wire is left undriven, so no two ports contend on it.

The block also sorts each access into one of two kinds. If the enable is already asserted while the port's address is on the bus, the access is a poll only and starts no transfer. If the port's address was on the bus while the enable was deasserted, and the enable then falls in the next cycle, the port is selected for a cell transfer. A one-cycle select strobe reports that case to the transfer logic, which lies outside this block. The cell count from the port's FIFO is an input. The pad ring combines the driven value and the output-enable into the tri-state pin. Address 0x1F is a null address that no port answers, even when software programs it as the port address.

Top module: `rxclav_responder`

## Requirements
- R1: A synchronous active-high reset sets the port address to 0x00 and clears clav_oe, clav_val, poll_hit and sel_start. After reset, address 0x00 is answered.
- R2: A configuration write (cfg_wr_en high at a rising edge) loads cfg_wr_data into the port address. Address compares use the new value from the next rising edge on. The compare at the write edge itself still uses the old value.
- R3: clav_oe is high during the clock period that follows an edge at which bus_addr equalled the port address. At every other time it is low.
- R4: While clav_oe is high, clav_val is 1 if fifo_cells, sampled at the matching edge, was nonzero, and 0 if it was zero. While clav_oe is low, clav_val is 0.
- R5: A bus address of 0x1F never causes an answer. This holds even when the port address is 0x1F, in which case the port answers no address at all.
- R6: poll_hit is high for the one period after an edge at which the address matched, bus_enb_n was 0 and no select was recognised.
- R7: sel_start is high for the one period after an edge at which bus_enb_n was 0, provided that at the edge before it the address matched and bus_enb_n was 1.
- R8: An edge at which the address does not match sets neither poll_hit nor, at the following edge, sel_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Port-address register write strobe |
| cfg_wr_data | input | 5 | New port address |
| bus_addr | input | 5 | Shared receive address bus |
| bus_enb_n | input | 1 | Shared active-low enable from the master |
| fifo_cells | input | CNT_W (4) | Whole cells held in this port's receive FIFO |
| clav_val | output | 1 | Value for the shared cell-available pin |
| clav_oe | output | 1 | Output enable for the shared cell-available pin |
| poll_hit | output | 1 | One-cycle strobe: this port was polled |
| sel_start | output | 1 | One-cycle strobe: this port was selected for transfer |

## Verification
The bench programs every one of the 32 port addresses in turn, including the null value. For each port it steps through all 32 bus addresses with the enable both deasserted and asserted. The cell count cycles through zero, one and full, so a match, a near miss and the null address each show whether the compare is exact and whether the answer is withheld. Because the accesses follow one another, the same sweep produces the orderings that separate a poll from a select: a match while enabled, a match that is followed by the enable falling, and a non-matching address before the enable falls. A configuration write shares its edge with a bus access, which shows whether the old or the new port address applies at that edge.

// File: rtl/rxclav_pkg.sv
package rxclav_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_POLL   = 2'd1,
    ACC_SELECT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rxclav_cfg_reg.sv
module rxclav_cfg_reg #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] port_addr
);
  always_ff @(posedge clk) begin
    if (rst)        port_addr <= '0;
    else if (wr_en) port_addr <= wr_data;
  end
endmodule

// File: rtl/rxclav_addr_match.sv
module rxclav_addr_match #(
  parameter int AW = 5,
  parameter bit RESERVE_NULL = 1'b1
) (
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] port_addr,
  output logic          hit
);
  logic eq;
  assign eq = (bus_addr == port_addr);

  generate
    if (RESERVE_NULL) begin : g_null
      localparam logic [AW-1:0] NULL_V = '1;
      assign hit = eq && (bus_addr != NULL_V);
    end else begin : g_plain
      assign hit = eq;
    end
  endgenerate
endmodule

// File: rtl/rxclav_clav_drv.sv
module rxclav_clav_drv #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [CW-1:0] cells,
  output logic          clav_val,
  output logic          clav_oe
);
  logic have_cell;
  assign have_cell = |cells;

  always_ff @(posedge clk) begin
    if (rst) begin
      clav_oe  <= 1'b0;
      clav_val <= 1'b0;
    end else begin
      clav_oe  <= hit;
      clav_val <= hit & have_cell;
    end
  end
endmodule

// File: rtl/rxclav_access_cls.sv
module rxclav_access_cls
  import rxclav_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic enb_n,
  output logic poll_hit,
  output logic sel_start
);
  logic      hit_q;
  logic      enb_n_q;
  acc_kind_e kind;

  always_comb begin
    kind = ACC_NONE;
    if (hit_q && enb_n_q && !enb_n) kind = ACC_SELECT;
    else if (hit && !enb_n)         kind = ACC_POLL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q     <= 1'b0;
      enb_n_q   <= 1'b1;
      poll_hit  <= 1'b0;
      sel_start <= 1'b0;
    end else begin
      hit_q     <= hit;
      enb_n_q   <= enb_n;
      poll_hit  <= (kind == ACC_POLL);
      sel_start <= (kind == ACC_SELECT);
    end
  end
endmodule

// File: rtl/rxclav_responder.sv
module rxclav_responder
  import rxclav_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_enb_n,
  input  logic [CNT_W-1:0]  fifo_cells,
  output logic              clav_val,
  output logic              clav_oe,
  output logic              poll_hit,
  output logic              sel_start
);
  logic [ADDR_W-1:0] port_addr_q;
  logic              hit;

  rxclav_cfg_reg #(.AW(ADDR_W)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .port_addr(port_addr_q)
  );

  rxclav_addr_match #(.AW(ADDR_W), .RESERVE_NULL(1'b1)) match_i (
    .bus_addr(bus_addr), .port_addr(port_addr_q), .hit(hit)
  );

  rxclav_clav_drv #(.CW(CNT_W)) drv_i (
    .clk(clk), .rst(rst), .hit(hit), .cells(fifo_cells),
    .clav_val(clav_val), .clav_oe(clav_oe)
  );

  rxclav_access_cls cls_i (
    .clk(clk), .rst(rst), .hit(hit), .enb_n(bus_enb_n),
    .poll_hit(poll_hit), .sel_start(sel_start)
  );
endmodule

// File: rtl/rxclav_responder_chk.sv
module rxclav_responder_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr_en,
  input logic [4:0] cfg_wr_data,
  input logic [4:0] bus_addr,
  input logic       bus_enb_n,
  input logic [4:0] port_addr_q,
  input logic       clav_val,
  input logic       clav_oe,
  input logic       poll_hit,
  input logic       sel_start
);
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en |=> (port_addr_q == $past(cfg_wr_data)));

  p_answer_match_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == port_addr_q && bus_addr != 5'h1F) |=> clav_oe);

  p_quiet_miss_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != port_addr_q) |=> !clav_oe);

  p_val_released_r4: assert property (@(posedge clk) disable iff (rst)
    !clav_oe |-> !clav_val);

  p_null_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 5'h1F) |=> !clav_oe);

  p_poll_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    (poll_hit && !$past(rst)) |-> ($past(bus_enb_n) == 1'b0 && $past(bus_addr) == $past(port_addr_q)));

  p_sel_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_start && !$past(rst)) |-> ($past(bus_enb_n) == 1'b0));

  p_one_kind_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({poll_hit, sel_start}));
endmodule

bind rxclav_responder rxclav_responder_chk chk_i (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .bus_addr(bus_addr), .bus_enb_n(bus_enb_n), .port_addr_q(port_addr_q),
  .clav_val(clav_val), .clav_oe(clav_oe), .poll_hit(poll_hit),
  .sel_start(sel_start)
);

// File: tb/rxclav_responder_tb_top.sv
module rxclav_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic [4:0] cfg_wr_data = '0;
  logic [4:0] bus_addr = 5'h1F;
  logic       bus_enb_n = 1'b1;
  logic [3:0] fifo_cells = '0;
  logic       clav_val, clav_oe, poll_hit, sel_start;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [4:0] m_port;
  logic       m_prev_hit;
  logic       m_prev_e;

  always #2 clk = ~clk;

  rxclav_responder dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .bus_addr(bus_addr), .bus_enb_n(bus_enb_n), .fifo_cells(fifo_cells),
    .clav_val(clav_val), .clav_oe(clav_oe), .poll_hit(poll_hit),
    .sel_start(sel_start)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(input logic wr, input logic [4:0] wd,
                      input logic [4:0] a, input logic e, input logic [3:0] c);
    logic hit, sel, poll;
    @(negedge clk);
    cfg_wr_en = wr; cfg_wr_data = wd;
    bus_addr = a; bus_enb_n = e; fifo_cells = c;
    hit  = (a == m_port) && (a != 5'h1F);
    sel  = m_prev_hit && m_prev_e && !e;
    poll = hit && !e && !sel;
    @(posedge clk); #1;
    check(hit ? "R3" : ((a == 5'h1F) ? "R5" : "R3"), "clav_oe", clav_oe, hit);
    check("R4", "clav_val", clav_val, hit && (c != 0));
    check(hit ? "R6" : "R8", "poll_hit", poll_hit, poll);
    check(m_prev_hit ? "R7" : "R8", "sel_start", sel_start, sel);
    if (wr) m_port = wd;
    m_prev_hit = hit;
    m_prev_e = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_port = 5'h00; m_prev_hit = 1'b0; m_prev_e = 1'b1;
    // R1: reset clears outputs, even with a matching address on the bus
    bus_addr = 5'h00; bus_enb_n = 1'b0; fifo_cells = 4'd3;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "clav_oe in reset", clav_oe, 1'b0);
    check("R1", "clav_val in reset", clav_val, 1'b0);
    check("R1", "poll_hit in reset", poll_hit, 1'b0);
    check("R1", "sel_start in reset", sel_start, 1'b0);
    @(negedge clk); rst = 1'b0; bus_addr = 5'h1F; bus_enb_n = 1'b1;
    // R1: port address after reset is 0x00
    step(1'b0, 5'h00, 5'h00, 1'b1, 4'd1);
    // R2: write edge still uses old address, new one applies after
    step(1'b1, 5'h05, 5'h05, 1'b1, 4'd1);
    step(1'b0, 5'h00, 5'h00, 1'b1, 4'd1);
    step(1'b0, 5'h00, 5'h05, 1'b1, 4'd0);
    // R7: select after matched address with enable high
    step(1'b0, 5'h00, 5'h05, 1'b0, 4'd0);
    // Sweep: every port address, every bus address, both enable levels
    for (int p = 0; p < 32; p++) begin
      step(1'b1, 5'(p), 5'h1F, 1'b1, 4'd0);
      for (int a = 0; a < 32; a++) begin
        for (int e = 0; e < 2; e++) begin
          int k;
          logic [3:0] cv;
          k = (a + e + p) % 3;
          cv = (k == 0) ? 4'd0 : ((k == 1) ? 4'd1 : 4'd15);
          step(1'b0, 5'h00, 5'(a), e[0], cv);
        end
      end
      // R7/R8: matched-then-enable-fall and miss-then-enable-fall
      step(1'b0, 5'h00, 5'(p), 1'b1, 4'd2);
      step(1'b0, 5'h00, 5'(p + 1), 1'b0, 4'd2);
      step(1'b0, 5'h00, 5'(p + 2), 1'b1, 4'd2);
      step(1'b0, 5'h00, 5'(p), 1'b0, 4'd2);
    end
    finish_run();
  end
endmodule